// File: doc/BRIEF.md
# Switchable Machine-Cycle Clock Generator

This block sits next to the crystal input of an 8051-class microcontroller and produces the timing reference shared by the CPU core and its peripherals. It runs entirely on the crystal clock. Its outputs are enables and strobes, not derived clocks. A core clock enable marks the crystal periods in which the internal clock advances. A machine-cycle strobe marks the last crystal period of every machine cycle. A peripheral tick paces timers and baud-rate logic.

One control bit, held in a special function register at address 0x8F, selects the rate. In normal mode the internal clock runs at half the crystal rate and a machine cycle lasts 12 crystal periods. In fast mode the internal clock equals the crystal rate and a machine cycle lasts 6 crystal periods. Because the peripheral tick is counted in machine cycles, every peripheral interval halves in fast mode. For example, a 20 ms timer period becomes 10 ms, and a 4800 baud base becomes 9600 baud.

A written mode request is held pending until the machine cycle in progress ends. This means no machine cycle is ever cut short or stretched part-way through. A four-state controller tracks the mode:

- ST_NORMAL: running normal, nothing pending.
- ST_ARM_FAST: running normal, fast requested.
- ST_FAST: running fast, nothing pending.
- ST_ARM_NORMAL: running fast, normal requested.

The controller makes these transitions:

- Request set: ST_NORMAL to ST_ARM_FAST, or directly to ST_FAST at a boundary.
- Request cleared: ST_FAST to ST_ARM_NORMAL, or directly to ST_NORMAL at a boundary.
- Boundary: ST_ARM_FAST to ST_FAST, and ST_ARM_NORMAL to ST_NORMAL.
- Cancel (request withdrawn before the boundary): ST_ARM_FAST back to ST_NORMAL, and ST_ARM_NORMAL back to ST_FAST.

Top module: `mcyc_clkgen`

## Requirements
- R1: After reset the block is in normal mode: `fast_active` is 0, `mcyc_phase` is 0, and a read of address 0x8F returns 0x00.
- R2: A write with `sfr_we`=1 and `sfr_addr`=0x8F stores `sfr_wdata` bit 0 as the speed request. A read at 0x8F returns that request in bit 0, combinationally in the same cycle. Reads at any other address return 0x00, and writes to any other address leave the request unchanged.
- R3: Bits 7..1 of the register are not stored. They always read 0, and writing 1s to them has no effect.
- R4: In normal mode a machine cycle is 12 crystal periods, with phases 0..11. `core_clk_en` is 1 on odd phases only, so the internal clock runs at half the crystal rate.
- R5: In fast mode a machine cycle is 6 crystal periods, with phases 0..5, and `core_clk_en` is 1 in every crystal period.
- R6: A change of the speed request takes effect at the first machine-cycle boundary that follows the clock edge storing it. The machine cycle in progress keeps its old length. A request that is restored before that boundary causes no switch.
- R7: `periph_tick` pulses together with the strobe at the end of every second machine cycle, counted from reset. This gives a spacing of 24 crystal periods in normal mode and 12 in fast mode.
- R8: `mcyc_phase` advances by one each crystal period and returns to 0 after the last phase. `mcyc_strobe` is 1, for exactly one crystal period, only in that last phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_we | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| core_clk_en | output | 1 | Internal clock enable for the core |
| mcyc_strobe | output | 1 | Last crystal period of a machine cycle |
| periph_tick | output | 1 | Peripheral time-base pulse |
| mcyc_phase | output | 4 | Crystal period index within the machine cycle |
| fast_active | output | 1 | 1 while fast mode is in effect |

## Verification
Read data follows the address in the same cycle. A write becomes visible one clock edge later. A mode change shows up only after the strobe that ends the current machine cycle, so its effect can lie up to 12 edges after the write. The bench drives inputs on the falling edge. It advances its own arithmetic model on each rising edge and compares every output 1 ns after the falling edge, so each result is judged in the cycle its registers make it due. Writes are swept across every phase of both modes, including the boundary phase and a cancelled request. Strobe and tick spacings are then measured in steady state.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    localparam int SFR_AW = 8;
    localparam int SFR_DW = 8;
    localparam logic [SFR_AW-1:0] CKCTL_ADDR_DEF = 8'h8F;
    localparam int SPEED_BIT = 0;

    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_ARM_FAST   = 2'd1,
        ST_FAST       = 2'd2,
        ST_ARM_NORMAL = 2'd3
    } speed_state_t;

endpackage

// File: rtl/mcg_ctrl_reg.sv
module mcg_ctrl_reg
    import mcg_pkg::*;
#(
    parameter logic [SFR_AW-1:0] REG_ADDR = CKCTL_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] addr,
    input  logic              we,
    input  logic [SFR_DW-1:0] wdata,
    output logic [SFR_DW-1:0] rdata,
    output logic              speed_req
);

    logic hit;
    assign hit = (addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_req <= 1'b0;
        end else if (we && hit) begin
            speed_req <= wdata[SPEED_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[SPEED_BIT] = speed_req;
        end
    end

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> (speed_req == $past(wdata[SPEED_BIT]))); // R2
    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit) |=> $stable(speed_req)); // R2

endmodule

// File: rtl/mcg_speed_fsm.sv
module mcg_speed_fsm
    import mcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic speed_req,
    input  logic boundary,
    output logic fast_active,
    output logic pending
);

    speed_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_NORMAL: begin
                if (speed_req) state_nxt = boundary ? ST_FAST : ST_ARM_FAST;
            end
            ST_ARM_FAST: begin
                if (!speed_req)    state_nxt = ST_NORMAL;
                else if (boundary) state_nxt = ST_FAST;
            end
            ST_FAST: begin
                if (!speed_req) state_nxt = boundary ? ST_NORMAL : ST_ARM_NORMAL;
            end
            ST_ARM_NORMAL: begin
                if (speed_req)     state_nxt = ST_FAST;
                else if (boundary) state_nxt = ST_NORMAL;
            end
            default: state_nxt = ST_NORMAL;
        endcase
    end

    always_comb begin
        fast_active = 1'b0;
        pending     = 1'b0;
        unique case (state)
            ST_NORMAL:     begin fast_active = 1'b0; pending = 1'b0; end
            ST_ARM_FAST:   begin fast_active = 1'b0; pending = 1'b1; end
            ST_FAST:       begin fast_active = 1'b1; pending = 1'b0; end
            ST_ARM_NORMAL: begin fast_active = 1'b1; pending = 1'b1; end
            default:       begin fast_active = 1'b0; pending = 1'b0; end
        endcase
    end

    AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fast_active) |-> $past(boundary)); // R6
    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && boundary) |=> !pending); // R6

endmodule

// File: rtl/mcg_phase_gen.sv
module mcg_phase_gen #(
    parameter int STD_LEN  = 12,
    parameter int FAST_LEN = 6,
    parameter int TICK_DIV = 2,
    localparam int PHASE_W = $clog2(STD_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fast_active,
    output logic [PHASE_W-1:0] phase,
    output logic               boundary,
    output logic               core_clk_en,
    output logic               periph_tick
);

    localparam logic [PHASE_W-1:0] STD_LAST  = PHASE_W'(STD_LEN - 1);
    localparam logic [PHASE_W-1:0] FAST_LAST = PHASE_W'(FAST_LEN - 1);

    logic [PHASE_W-1:0] last_phase;
    assign last_phase  = fast_active ? FAST_LAST : STD_LAST;
    assign boundary    = (phase == last_phase);
    assign core_clk_en = fast_active ? 1'b1 : phase[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (boundary) begin
            phase <= '0;
        end else begin
            phase <= phase + PHASE_W'(1);
        end
    end

    generate
        if (TICK_DIV <= 1) begin : g_tick_direct
            assign periph_tick = boundary;
        end else begin : g_tick_div
            localparam int MC_W = $clog2(TICK_DIV);
            localparam logic [MC_W-1:0] MC_LAST = MC_W'(TICK_DIV - 1);
            logic [MC_W-1:0] mc_cnt;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mc_cnt <= '0;
                end else if (boundary) begin
                    mc_cnt <= (mc_cnt == MC_LAST) ? '0 : mc_cnt + MC_W'(1);
                end
            end
            assign periph_tick = boundary && (mc_cnt == MC_LAST);
        end
    endgenerate

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= last_phase); // R8
    AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (phase == '0)); // R8
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> (phase == $past(phase) + PHASE_W'(1))); // R8
    AST_NORMAL_EN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_active && core_clk_en && !boundary) |=> !core_clk_en); // R4
    AST_FAST_EN_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        fast_active |-> core_clk_en); // R5
    AST_TICK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        periph_tick |-> boundary); // R7

endmodule

// File: rtl/mcyc_clkgen.sv
module mcyc_clkgen
    import mcg_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = CKCTL_ADDR_DEF,
    parameter int STD_LEN  = 12,
    parameter int FAST_LEN = 6,
    parameter int TICK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_we,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    output logic       core_clk_en,
    output logic       mcyc_strobe,
    output logic       periph_tick,
    output logic [3:0] mcyc_phase,
    output logic       fast_active
);

    logic speed_req;
    logic boundary;
    logic pending;

    mcg_ctrl_reg #(.REG_ADDR(CTRL_ADDR)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (sfr_addr),
        .we        (sfr_we),
        .wdata     (sfr_wdata),
        .rdata     (sfr_rdata),
        .speed_req (speed_req)
    );

    mcg_speed_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_req   (speed_req),
        .boundary    (boundary),
        .fast_active (fast_active),
        .pending     (pending)
    );

    mcg_phase_gen #(
        .STD_LEN  (STD_LEN),
        .FAST_LEN (FAST_LEN),
        .TICK_DIV (TICK_DIV)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_active (fast_active),
        .phase       (mcyc_phase),
        .boundary    (boundary),
        .core_clk_en (core_clk_en),
        .periph_tick (periph_tick)
    );

    assign mcyc_strobe = boundary;

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == CTRL_ADDR) |-> (sfr_rdata[7:1] == 7'd0)); // R3
    AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != CTRL_ADDR) |-> (sfr_rdata == 8'd0)); // R2
    AST_READ_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == CTRL_ADDR) |-> (sfr_rdata[0] == speed_req)); // R2
    AST_PENDING_MEANS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (speed_req != fast_active) || $past(sfr_we)); // R6

endmodule

// File: tb/tb_mcyc_clkgen.sv
module tb_mcyc_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       core_clk_en, mcyc_strobe, periph_tick, fast_active;
    logic [3:0] mcyc_phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit cmp_on  = 1'b0;

    always #2.5 clk = ~clk;

    mcyc_clkgen dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .core_clk_en(core_clk_en),
        .mcyc_strobe(mcyc_strobe), .periph_tick(periph_tick),
        .mcyc_phase(mcyc_phase), .fast_active(fast_active)
    );

    // Arithmetic reference model
    logic       m_req = 1'b0, m_fast = 1'b0;
    int         m_cnt = 0, m_mc = 0;

    function automatic int mlen(input logic f);
        return f ? 6 : 12;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req <= 1'b0; m_fast <= 1'b0; m_cnt <= 0; m_mc <= 0;
        end else begin
            if (sfr_we && sfr_addr == 8'h8F) m_req <= sfr_wdata[0];
            if (m_cnt == mlen(m_fast) - 1) begin
                m_cnt  <= 0;
                m_fast <= m_req;
                m_mc   <= (m_mc == 1) ? 0 : m_mc + 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            logic bnd;
            bnd = (m_cnt == mlen(m_fast) - 1);
            chk("R8 phase", mcyc_phase, m_cnt);
            chk("R8 strobe", mcyc_strobe, bnd);
            chk("R6 fast_active", fast_active, m_fast);
            chk(m_fast ? "R5 core_clk_en" : "R4 core_clk_en", core_clk_en,
                m_fast ? 1 : (m_cnt % 2));
            chk("R7 periph_tick", periph_tick, (bnd && m_mc == 1) ? 1 : 0);
            chk("R2 rdata", sfr_rdata, (sfr_addr == 8'h8F) ? {7'd0, m_req} : 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_we = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0; sfr_wdata = 8'h00;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        while (mcyc_phase != 4'(p)) @(negedge clk);
    endtask

    // Crystal periods between successive pulses of strobe (sel=0) or tick (sel=1)
    task automatic gap(input bit sel, output int n);
        @(negedge clk); #1;
        while ((sel ? periph_tick : mcyc_strobe) !== 1'b1) begin @(negedge clk); #1; end
        n = 0;
        do begin @(negedge clk); #1; n++; end
        while ((sel ? periph_tick : mcyc_strobe) !== 1'b1 && n < 100);
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        int g;
        run(4);
        rst_n = 1'b1;
        #1;
        sfr_addr = 8'h8F;
        #1;
        chk("R1 reset fast_active", fast_active, 0);
        chk("R1 reset phase", mcyc_phase, 0);
        chk("R1 reset rdata", sfr_rdata, 0);
        @(negedge clk);
        cmp_on = 1'b1;

        // Steady normal mode
        gap(0, g); chk("R4 normal mcycle length", g, 12);
        gap(1, g); chk("R7 normal tick spacing", g, 24);

        // Foreign address write ignored, read zero
        wr(8'h8E, 8'hFF);
        sfr_addr = 8'h8E; run(1);
        sfr_addr = 8'h8F; #1;
        chk("R2 foreign write ignored", sfr_rdata, 0);
        run(20);
        chk("R2 still normal", fast_active, 0);

        // Reserved bits ignored; bit0 set
        wr(8'h8F, 8'hFE); #1;
        chk("R3 reserved only", sfr_rdata, 0);
        run(14);
        wr(8'h8F, 8'hFF); #1;
        chk("R3 reserved read zero", sfr_rdata, 8'h01);
        run(14);
        gap(0, g); chk("R5 fast mcycle length", g, 6);
        gap(1, g); chk("R7 fast tick spacing", g, 12);
        wr(8'h8F, 8'h00);
        run(14);

        // Sweep switching at every phase, both directions
        for (int p = 0; p < 12; p++) begin
            wait_phase(p);
            wr(8'h8F, 8'h01);
            run(30);
            wait_phase(p % 6);
            wr(8'h8F, 8'h00);
            run(30);
        end

        // Cancelled requests (R6)
        for (int p = 0; p < 9; p++) begin
            wait_phase(p);
            wr(8'h8F, 8'h01);
            wr(8'h8F, 8'h00);
            run(1);
            chk("R6 cancel keeps normal", fast_active, 0);
            run(14);
        end
        wr(8'h8F, 8'h01);
        run(20);
        for (int p = 0; p < 3; p++) begin
            wait_phase(p);
            wr(8'h8F, 8'h00);
            wr(8'h8F, 8'h01);
            run(8);
            chk("R6 cancel keeps fast", fast_active, 1);
        end

        // Reset mid-fast returns to normal
        rst_n = 1'b0; cmp_on = 1'b0;
        run(2);
        rst_n = 1'b1; #1;
        chk("R1 re-reset fast_active", fast_active, 0);
        chk("R1 re-reset rdata", sfr_rdata, 0);
        @(negedge clk); cmp_on = 1'b1;
        run(40);

        cmp_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

endmodule